// File: doc/BRIEF.md
# Write-Once Timing Tick Divider for Nonvolatile-Memory Sequencing

This block turns a fast oscillator clock into a slow, periodic timing tick that program and erase sequencers use to time their steps. Software configures it through one byte-wide register on a simple memory-mapped port. The byte holds an optional fixed divide-by-8 prescaler enable and a 6-bit divide field. The first accepted write after reset sets the configuration and locks it until the next reset.

A read-only flag in the same register, also brought out as a pin, shows that the configuration has been loaded. Downstream command logic can use this flag to refuse operations while the timing is undefined. The tick is a one-cycle enable pulse in the oscillator domain, not a derived clock. It stays low until the configuration is loaded. Software is expected to pick settings that place the tick rate between 150 kHz and 200 kHz.

Top module: `nvm_tick_divider`

## Requirements
- R1: The register sits at address `REG_ADDR`. Bit 7 is the loaded flag, bit 6 is the prescaler enable and bits 5:0 are the divide field. `busRdata` shows the register whenever `busAddr` equals `REG_ADDR` and reads 0x00 at any other address.
- R2: While reset is asserted, every register bit reads 0 and `tickPulse` is low.
- R3: The first accepted write stores `busWdata[6:0]` into bits 6:0 and sets bit 7 to 1. The new value is visible from the next cycle.
- R4: Once bit 7 is 1, later writes leave the whole register unchanged.
- R5: Bit 7 cannot be written. A first write with `busWdata[7]`=0 still reads back bit 7 as 1, and before any write the bit reads 0 even when a write carries a 1 in bit 7 to a non-matching address.
- R6: A write is accepted only when `busSel`, `busWrite` and an address match are all present in the same cycle. Any other combination has no effect.
- R7: A write presented on the first clock edge after reset is released is ignored.
- R8: With the prescaler enable at 0, `tickPulse` repeats every divide field + 1 oscillator cycles.
- R9: With the prescaler enable at 1, `tickPulse` repeats every 8 × (divide field + 1) cycles, which is 512 at the largest setting.
- R10: `tickPulse` is low whenever the loaded flag is 0. When the period exceeds one cycle, each pulse lasts exactly one cycle.
- R11: Only reset releases the lock. After a new reset, the next write is accepted and sets a new setting.
- R12: `dividerLoaded` always equals register bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access select |
| busWrite | input | 1 | Write strobe, qualified by busSel |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| tickPulse | output | 1 | One-cycle timing enable |
| dividerLoaded | output | 1 | Configuration loaded and locked |

## Verification
A lock that fails to hold, or a lock that sets wrongly, shows at the read port on the cycle after the offending write. It also changes the tick period within one period. A wrong prescaler or divider count state shows as a wrong spacing between two consecutive tick pulses, so each setting is judged after at most two periods (1024 cycles at the largest setting). A load taken on the reset-release edge shows as the loaded flag rising one cycle after reset is released.

// File: rtl/nvmdiv_pkg.sv
package nvmdiv_pkg;
  // width of the programmable divide field (bits 5:0 of the register)
  localparam int DIV_W = 6;
  localparam int REG_W = DIV_W + 2;

  // configuration handed from control to datapath
  typedef struct packed {
    logic             run;       // divider enabled (configuration loaded)
    logic             prescale;  // insert the fixed pre-divider
    logic [DIV_W-1:0] limit;     // terminal count of the main divider
  } divCfg_t;
endpackage

// File: rtl/nvmdiv_ctrl.sv
module nvmdiv_ctrl
  import nvmdiv_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  regValue,
  output divCfg_t           cfg
);
  logic             settled;
  logic             loaded;
  logic             prescale;
  logic [DIV_W-1:0] divField;
  logic             wrHit;
  logic             unusedWrTop;

  // bit 7 of the write data is never stored
  assign unusedWrTop = busWdata[REG_W-1];

  // low for the first edge after reset release: blocks writes on that edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) settled <= 1'b0;
    else       settled <= 1'b1;
  end

  assign wrHit = settled && busSel && busWrite && (busAddr == REG_ADDR) && !loaded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loaded   <= 1'b0;
      prescale <= 1'b0;
      divField <= '0;
    end else if (wrHit) begin
      loaded   <= 1'b1;
      prescale <= busWdata[DIV_W];
      divField <= busWdata[DIV_W-1:0];
    end
  end

  assign regValue     = {loaded, prescale, divField};
  assign cfg.run      = loaded;
  assign cfg.prescale = prescale;
  assign cfg.limit    = divField;
endmodule

// File: rtl/nvmdiv_datapath.sv
module nvmdiv_datapath
  import nvmdiv_pkg::*;
#(
  parameter int PRE_LOG2 = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  divCfg_t cfg,
  output logic    tickPulse
);
  logic             preTick;
  logic [DIV_W-1:0] divCnt;
  logic             hit;

  generate
    if (PRE_LOG2 > 0) begin : g_pre
      logic [PRE_LOG2-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                         preCnt <= '0;
        else if (!cfg.run || !cfg.prescale) preCnt <= '0;
        else                               preCnt <= preCnt + 1'b1;
      end
      assign preTick = cfg.prescale ? (&preCnt) : 1'b1;
    end else begin : g_nopre
      assign preTick = 1'b1;
    end
  endgenerate

  assign hit = cfg.run && preTick && (divCnt == cfg.limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             divCnt <= '0;
    else if (!cfg.run)     divCnt <= '0;
    else if (hit)          divCnt <= '0;
    else if (preTick)      divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickPulse <= 1'b0;
    else       tickPulse <= hit;
  end
endmodule

// File: rtl/nvm_tick_divider.sv
module nvm_tick_divider
  import nvmdiv_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter int PRE_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              tickPulse,
  output logic              dividerLoaded
);
  logic [REG_W-1:0] regValue;
  divCfg_t          cfg;

  nvmdiv_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .regValue(regValue), .cfg(cfg)
  );

  nvmdiv_datapath #(.PRE_LOG2(PRE_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .tickPulse(tickPulse)
  );

  assign busRdata      = (busAddr == REG_ADDR) ? regValue : '0;
  assign dividerLoaded = regValue[REG_W-1];
endmodule

// File: rtl/nvm_tick_divider_chk.sv
module nvm_tick_divider_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        regValue,
  input logic              tickPulse,
  input logic              dividerLoaded
);
  assert_reset_clear_R2: assert property (@(posedge clk)
    !rstN |-> (regValue == 8'h00 && !tickPulse));

  assert_loaded_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    regValue[7] |=> regValue[7]);

  assert_lock_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    regValue[7] |=> $stable(regValue));

  assert_load_needs_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regValue[7]) |-> $past(busSel && busWrite && (busAddr == REG_ADDR)));

  assert_release_write_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |=> !regValue[7]);

  assert_tick_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |-> dividerLoaded);
endmodule

bind nvm_tick_divider nvm_tick_divider_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
  .regValue(regValue), .tickPulse(tickPulse), .dividerLoaded(dividerLoaded)
);

// File: tb/test_nvm_tick_divider.sv
module test_nvm_tick_divider;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] REG_ADDR = 8'h00;
  localparam int WATCHDOG = 100000;
  localparam int NVEC = 7;
  localparam logic [7:0] VEC_DATA [NVEC] = '{8'h00, 8'h05, 8'h3F, 8'h40, 8'h43, 8'h4A, 8'h7F};
  localparam int         VEC_PER  [NVEC] = '{1, 6, 64, 8, 32, 88, 512};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0;
  logic busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic tickPulse;
  logic dividerLoaded;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_tick_divider #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_nvm_tick_divider (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .tickPulse(tickPulse),
    .dividerLoaded(dividerLoaded)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic busWr(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                       input logic s, input logic w);
    busSel = s; busWrite = w; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busAddr = REG_ADDR; busWdata = 8'h00;
  endtask

  task automatic measure(output int per);
    int guard;
    guard = 0;
    while (!tickPulse && guard < 2000) begin @(negedge clk); guard++; end
    per = 0;
    do begin @(negedge clk); per++; end while (!tickPulse && per < 2000);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int per;
    // R2: reset state
    #(CLK_PERIOD*2 + 1);
    check(busRdata == 8'h00, "R2", busRdata, 0);
    check(!tickPulse && !dividerLoaded, "R2", {tickPulse, dividerLoaded}, 0);

    // vector walk: R3, R8, R9, R1, R12
    for (int i = 0; i < NVEC; i++) begin
      doReset();
      busWr(REG_ADDR, VEC_DATA[i], 1'b1, 1'b1);
      check(busRdata == (VEC_DATA[i] | 8'h80), "R3", busRdata, VEC_DATA[i] | 8'h80);
      check(dividerLoaded == busRdata[7], "R12", dividerLoaded, busRdata[7]);
      measure(per);
      measure(per);
      check(per == VEC_PER[i], VEC_DATA[i][6] ? "R9" : "R8", per, VEC_PER[i]);
    end

    // R4: second write rejected, period unchanged
    doReset();
    busWr(REG_ADDR, 8'h05, 1'b1, 1'b1);
    busWr(REG_ADDR, 8'h7F, 1'b1, 1'b1);
    check(busRdata == 8'h85, "R4", busRdata, 8'h85);
    measure(per); measure(per);
    check(per == 6, "R4", per, 6);
    // R1: other address reads zero
    busAddr = 8'h01; #1;
    check(busRdata == 8'h00, "R1", busRdata, 0);
    busAddr = REG_ADDR;

    // R6, R5, R10: non-qualified writes ignored, tick low while unloaded
    doReset();
    busWr(REG_ADDR, 8'hC3, 1'b0, 1'b1);
    busWr(REG_ADDR, 8'hC3, 1'b1, 1'b0);
    busWr(8'h02,    8'hC3, 1'b1, 1'b1);
    check(busRdata == 8'h00, "R6", busRdata, 0);
    check(!dividerLoaded, "R5", dividerLoaded, 0);
    per = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (tickPulse) per++; end
    check(per == 0, "R10", per, 0);
    // R5: bit 7 written as 0 still reads 1
    busWr(REG_ADDR, 8'h02, 1'b1, 1'b1);
    check(busRdata == 8'h82, "R5", busRdata, 8'h82);
    // R10: single-cycle pulse width
    measure(per);
    @(negedge clk);
    check(!tickPulse, "R10", tickPulse, 0);

    // R7: write on the reset-release edge is ignored
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    busSel = 1'b1; busWrite = 1'b1; busAddr = REG_ADDR; busWdata = 8'h45;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = 8'h00;
    check(busRdata == 8'h00, "R7", busRdata, 0);

    // R11: lock released only by reset; new setting accepted after it
    busWr(REG_ADDR, 8'h45, 1'b1, 1'b1);
    check(busRdata == 8'hC5, "R11", busRdata, 8'hC5);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(busRdata == 8'h00 && !tickPulse, "R2", busRdata, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    busWr(REG_ADDR, 8'h01, 1'b1, 1'b1);
    check(busRdata == 8'h81, "R11", busRdata, 8'h81);
    measure(per); measure(per);
    check(per == 2, "R11", per, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule